// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block lets a bus master fetch serial NOR flash contents as if the flash were ordinary memory. The master holds a request valid with a system address. The engine splits that address into a device index and an in-device offset; every device owns one fixed window of `2**WIN_BITS` bytes. It then runs a complete flash read on the SPI pins: an opcode, then the address, then an optional run of dummy clocks, then the data burst. When the last data byte has arrived, it answers with a one-cycle ready pulse. The whole burst is presented at once on a 128-bit data bus in little-endian byte order.

One 32-bit configuration word sets how the read is built: the opcode, the lane mode (single, dual, quad, or quad for every phase), the dummy length, 3- or 4-byte addressing and the burst size. A lock bit freezes the word until reset. The engine takes a snapshot of the word when each burst starts, so a write that lands during a burst only affects the next one. The SPI clock runs in mode 0. Outputs change after the falling edge, inputs are sampled on the rising edge, and the clock idles low. Each half period lasts `HALF_DIV` system clocks.

Top module: `flash_read_engine`

## Requirements
- R1: Configuration bits 7:0 are the opcode. In lane modes 0 to 2 it is sent first on `spi_io_out[0]` alone, most significant bit first, over 8 SPI clocks.
- R2: Configuration bits 9:8 select the lane count for the address, dummy and data phases: 0 gives one lane (out on io0, in on io1), 1 gives two lanes (io1:io0), 2 and 3 give four lanes (io3:io0). The higher-numbered lane carries the more significant bit. The output enable covers exactly the active lanes in the command and address phases.
- R3: In lane mode 3 the command phase also uses four lanes and lasts 2 SPI clocks.
- R4: Configuration bits 13:12 give a dummy length of 0 to 3 bytes. This is sent as bytes×8/lanes SPI clocks. All output enables are low during the dummy and data phases, so the total number of SPI clocks in a burst is exactly command + address + dummy + data.
- R5: When configuration bits 17:16 are 0, the low 24 bits of the offset are sent. Any other value sends all 32 bits, with the offset zero-extended. The address goes out most significant bit first.
- R6: Configuration bits 25:24 set the burst size: 0 gives 4 bytes, 1 gives 8 bytes, 2 and 3 give 16 bytes. The byte read from flash offset+k appears on `rd_data[8k+7:8k]`, and the bytes past the burst are zero.
- R7: While configuration bit 31 is set, writes to the configuration word are ignored until reset.
- R8: The device index is `req_addr >> WIN_BITS` and the offset is the low `WIN_BITS` bits. Only `spi_cs_n[index]` goes low, and it stays low for the whole burst.
- R9: `req_ready` is high for exactly one cycle after the last data bit has been sampled, and `rd_data` holds the burst in that cycle.
- R10: Chip select stays high with the SPI clock low and no lane driven between bursts. If a request is already waiting, the next burst lowers chip select exactly `2*HALF_DIV+1` system clocks after the previous one raised it.
- R11: After reset the configuration reads 0x0300100B: opcode 0x0B, single lane, one dummy byte, 3-byte address, 16-byte burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Current configuration word |
| req_valid | input | 1 | Read request, held until `req_ready` |
| req_addr | input | WIN_BITS+log2(NUM_CS) | System byte address of the burst |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 128 | Burst data, little-endian bytes |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | NUM_CS | Active-low device selects |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |

## Verification
Two things can happen in the same cycle: the end of one burst and a change to the configuration or request for the next. The bench keeps the request valid throughout. In the very cycle it sees the ready pulse, it presents the next address and writes a new configuration word. The bench then checks that the next burst lowers chip select exactly `2*HALF_DIV+1` cycles after the previous burst raised it. It also checks that the new burst uses the new opcode, lane mode, dummy and address widths, so that neither the snapshot nor the finishing burst is disturbed. The sweep covers every combination of lane mode, dummy length, address width and burst size in this chained manner. A flash model inside the bench decodes the pins and supplies data computed from the address it received.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int MAX_BURST_BYTES = 16;
    localparam int DATA_W          = MAX_BURST_BYTES * 8;
    localparam logic [31:0] CFG_RESET = 32'h0300_100B;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_DATA  = 3'd4,
        PH_GAP   = 3'd5
    } phase_e;

    // Full configuration word layout
    typedef struct packed {
        logic       lock;
        logic [4:0] rsv_top;
        logic [1:0] burst;
        logic [5:0] rsv_mid;
        logic [1:0] addr_sel;
        logic [1:0] rsv_b;
        logic [1:0] dummy;
        logic [1:0] rsv_a;
        logic [1:0] mode;
        logic [7:0] opcode;
    } cfg_t;

    // Fields the sequencer snapshots per burst
    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] mode;
        logic [1:0] dummy;
        logic       addr4;
        logic [1:0] burst;
    } rd_cfg_t;

    function automatic logic [2:0] lanes_of(input logic [1:0] mode);
        case (mode)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] cmd_lanes_of(input logic [1:0] mode);
        return (mode == 2'd3) ? 3'd4 : 3'd1;
    endfunction

    function automatic logic [4:0] burst_bytes(input logic [1:0] b);
        case (b)
            2'd0:    return 5'd4;
            2'd1:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [2:0] lanes);
        case (lanes)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/fr_cfg_reg.sv
module fr_cfg_reg
    import fr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] word_o
);

    logic [31:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        // Once the lock bit is set the word is frozen until reset
        if (we && !word_q[31]) begin
            word_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= CFG_RESET;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/fr_addr_map.sv
module fr_addr_map #(
    parameter  int NUM_CS   = 4,
    parameter  int WIN_BITS = 24,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W   = WIN_BITS + CS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CS_W-1:0]   cs_idx,
    output logic [31:0]       offset
);

    // One fixed window per device: upper bits pick the device
    assign cs_idx = addr[ADDR_W-1:WIN_BITS];
    assign offset = 32'(addr[WIN_BITS-1:0]);

endmodule

// File: rtl/fr_seq.sv
module fr_seq
    import fr_pkg::*;
#(
    parameter  int NUM_CS   = 4,
    parameter  int HALF_DIV = 2,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int HC_W     = $clog2(2 * HALF_DIV) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_cfg_t           cfg_i,
    input  logic              req_valid,
    input  logic [CS_W-1:0]   cs_idx_i,
    input  logic [31:0]       offset_i,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    typedef struct packed {
        phase_e            ph;
        rd_cfg_t           cfg;
        logic [CS_W-1:0]   cs;
        logic [31:0]       off;
        logic [HC_W-1:0]   hc;
        logic              sclk;
        logic [7:0]        bits;
        logic [31:0]       tx;
        logic [7:0]        rxb;
        logic [DATA_W-1:0] data;
        logic              done;
    } st_t;

    st_t s_d, s_q;

    logic [2:0] lanes;
    logic [7:0] len;
    logic [7:0] nbits;
    logic [7:0] in_bits;
    logic [7:0] rx_next;
    logic       active;

    // Lane count and phase length in bits for the current phase
    always_comb begin
        lanes = (s_q.ph == PH_CMD) ? cmd_lanes_of(s_q.cfg.mode) : lanes_of(s_q.cfg.mode);
        case (s_q.ph)
            PH_CMD:   len = 8'd8;
            PH_ADDR:  len = s_q.cfg.addr4 ? 8'd32 : 8'd24;
            PH_DUMMY: len = {3'b000, s_q.cfg.dummy, 3'b000};
            PH_DATA:  len = {burst_bytes(s_q.cfg.burst), 3'b000};
            default:  len = 8'd0;
        endcase
        case (lanes)
            3'd1:    in_bits = {7'd0, io_in[1]};
            3'd2:    in_bits = {6'd0, io_in[1:0]};
            default: in_bits = {4'd0, io_in[3:0]};
        endcase
        rx_next = 8'((s_q.rxb << lanes) | in_bits);
        nbits   = s_q.bits + {5'd0, lanes};
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph   = PH_CMD;
                    s_d.cfg  = cfg_i;
                    s_d.cs   = cs_idx_i;
                    s_d.off  = offset_i;
                    s_d.hc   = '0;
                    s_d.sclk = 1'b0;
                    s_d.bits = '0;
                    s_d.tx   = {cfg_i.opcode, 24'd0};
                    s_d.rxb  = '0;
                    s_d.data = '0;
                end
            end
            PH_GAP: begin
                if (s_q.hc == HC_W'(2 * HALF_DIV - 1)) begin
                    s_d.ph = PH_IDLE;
                    s_d.hc = '0;
                end else begin
                    s_d.hc = s_q.hc + 1'b1;
                end
            end
            default: begin
                if (s_q.hc == HC_W'(HALF_DIV - 1)) begin
                    s_d.hc   = '0;
                    s_d.sclk = ~s_q.sclk;
                    if (!s_q.sclk) begin
                        // Rising edge: capture input lanes
                        if (s_q.ph == PH_DATA) begin
                            s_d.rxb = rx_next;
                            if (nbits[2:0] == 3'd0) begin
                                s_d.data[{s_q.bits[6:3], 3'b000} +: 8] = rx_next;
                            end
                        end
                    end else begin
                        // Falling edge: move to the next lane group
                        s_d.bits = nbits;
                        s_d.tx   = s_q.tx << lanes;
                        if (nbits >= len) begin
                            s_d.bits = '0;
                            case (s_q.ph)
                                PH_CMD: begin
                                    s_d.ph = PH_ADDR;
                                    s_d.tx = s_q.cfg.addr4 ? s_q.off : {s_q.off[23:0], 8'd0};
                                end
                                PH_ADDR: begin
                                    s_d.ph = (s_q.cfg.dummy != 2'd0) ? PH_DUMMY : PH_DATA;
                                end
                                PH_DUMMY: begin
                                    s_d.ph = PH_DATA;
                                end
                                default: begin
                                    s_d.ph   = PH_GAP;
                                    s_d.done = 1'b1;
                                end
                            endcase
                        end
                    end
                end else begin
                    s_d.hc = s_q.hc + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = (s_q.ph == PH_CMD) || (s_q.ph == PH_ADDR) ||
                    (s_q.ph == PH_DUMMY) || (s_q.ph == PH_DATA);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(active && (s_q.cs == CS_W'(i)));
    end

    always_comb begin
        case (lanes)
            3'd1:    io_out = {3'd0, s_q.tx[31]};
            3'd2:    io_out = {2'd0, s_q.tx[31:30]};
            default: io_out = s_q.tx[31:28];
        endcase
        io_oe = ((s_q.ph == PH_CMD) || (s_q.ph == PH_ADDR)) ? lane_mask(lanes) : 4'd0;
    end

    assign sclk      = s_q.sclk;
    assign req_ready = s_q.done;
    assign rd_data   = s_q.data;

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
    import fr_pkg::*;
#(
    parameter  int NUM_CS   = 4,
    parameter  int WIN_BITS = 24,
    parameter  int HALF_DIV = 2,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W   = WIN_BITS + CS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [127:0]      rd_data,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe,
    input  logic [3:0]        spi_io_in
);

    logic [31:0]     cfg_word;
    cfg_t            cw;
    rd_cfg_t         rcfg;
    logic [CS_W-1:0] cs_idx;
    logic [31:0]     offset;
    logic            unused_cfg_bits;

    fr_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .word_o (cfg_word)
    );

    assign cw        = cfg_t'(cfg_word);
    assign cfg_rdata = cfg_word;

    always_comb begin
        rcfg.opcode = cw.opcode;
        rcfg.mode   = cw.mode;
        rcfg.dummy  = cw.dummy;
        rcfg.addr4  = (cw.addr_sel != 2'd0);
        rcfg.burst  = cw.burst;
    end

    assign unused_cfg_bits = ^{cw.lock, cw.rsv_top, cw.rsv_mid, cw.rsv_b, cw.rsv_a};

    fr_addr_map #(
        .NUM_CS   (NUM_CS),
        .WIN_BITS (WIN_BITS)
    ) u_map (
        .addr   (req_addr),
        .cs_idx (cs_idx),
        .offset (offset)
    );

    fr_seq #(
        .NUM_CS   (NUM_CS),
        .HALF_DIV (HALF_DIV)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (rcfg),
        .req_valid (req_valid),
        .cs_idx_i  (cs_idx),
        .offset_i  (offset),
        .req_ready (req_ready),
        .rd_data   (rd_data),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .io_out    (spi_io_out),
        .io_oe     (spi_io_oe),
        .io_in     (spi_io_in)
    );

endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [31:0]       cfg_rdata,
    input logic              req_ready,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic [3:0]        spi_io_oe
);

    p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_ready_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&spi_cs_n && !spi_sclk));

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_rdata[31]) |=> (cfg_rdata == $past(cfg_rdata)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> (!spi_sclk && spi_io_oe == 4'd0));

    p_gap_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&spi_cs_n) |=> (&spi_cs_n));

endmodule

bind flash_read_engine fr_checker #(.NUM_CS(NUM_CS)) u_fr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .req_ready (req_ready),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_io_oe (spi_io_oe)
);

// File: tb/tb_flash_read_engine.sv
module tb_flash_read_engine;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1;
    localparam int NCS        = 4;
    localparam int WBITS      = 24;
    localparam int AW         = WBITS + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [31:0]    cfg_wdata = '0;
    logic [31:0]    cfg_rdata;
    logic           req_valid = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic           req_ready;
    logic [127:0]   rd_data;
    logic           spi_sclk;
    logic [NCS-1:0] spi_cs_n;
    logic [3:0]     spi_io_out;
    logic [3:0]     spi_io_oe;
    logic [3:0]     spi_io_in = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_read_engine #(
        .NUM_CS   (NCS),
        .WIN_BITS (WBITS),
        .HALF_DIV (HALF)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rd_data    (rd_data),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe),
        .spi_io_in  (spi_io_in)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int c, input logic [31:0] a);
        return 8'(a * 37 + (a >> 8) * 11 + (a >> 16) * 5 + c * 67 + 1);
    endfunction

    function automatic logic [3:0] take(input logic [3:0] v, input int n);
        if (n == 1) return {3'd0, v[0]};
        if (n == 2) return {2'd0, v[1:0]};
        return v;
    endfunction

    function automatic logic [3:0] mask_of(input int n);
        if (n == 1) return 4'b0001;
        if (n == 2) return 4'b0011;
        return 4'b1111;
    endfunction

    // Flash model state, expected phase layout set before each request
    int x_cl, x_l, x_cmdc, x_addrc, x_dumc;
    int e_cnt = 0;
    int oe_err = 0;
    int cap_cs = -1;
    logic [7:0]  cap_opc = '0;
    logic [31:0] cap_addr = '0;
    wire cs_any = &spi_cs_n;

    always @(negedge cs_any) begin
        e_cnt = 0;
        oe_err = 0;
        cap_opc = '0;
        cap_addr = '0;
        cap_cs = -1;
        for (int i = 0; i < NCS; i++) if (!spi_cs_n[i]) cap_cs = i;
    end

    always @(posedge spi_sclk) begin
        if (!cs_any) begin
            if (e_cnt < x_cmdc) begin
                cap_opc = 8'((cap_opc << x_cl) | take(spi_io_out, x_cl));
                if (spi_io_oe != mask_of(x_cl)) oe_err++;
            end else if (e_cnt < x_cmdc + x_addrc) begin
                cap_addr = (cap_addr << x_l) | 32'(take(spi_io_out, x_l));
                if (spi_io_oe != mask_of(x_l)) oe_err++;
            end else begin
                if (spi_io_oe != 4'd0) oe_err++;
            end
            e_cnt++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!cs_any) begin
            int g;
            g = e_cnt - (x_cmdc + x_addrc + x_dumc);
            if (g >= 0) begin
                int bp;
                logic [7:0] b;
                logic [3:0] v;
                bp = g * x_l;
                b  = fbyte(cap_cs, cap_addr + 32'(bp / 8));
                v  = take(4'(b >> (8 - x_l - (bp % 8))), x_l);
                spi_io_in = (x_l == 1) ? {2'd0, v[0], 1'b0} : v;
            end
        end
    end

    // Chip-select high time between bursts, in system clocks
    int hi_cnt = 0;
    int last_gap = 0;
    always @(negedge clk) begin
        if (cs_any) begin
            hi_cnt++;
        end else if (hi_cnt != 0) begin
            last_gap = hi_cnt;
            hi_cnt = 0;
        end
    end

    task automatic do_read(input logic [31:0] cv, input logic [AW-1:0] a,
                           input bit wr_cfg, input bit chained);
        int mode, l, cl, ab, db, nb, guard, ecs;
        logic [31:0]  off;
        logic [127:0] exp_d;
        string creq;
        mode = int'(cv[9:8]);
        l    = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        cl   = (mode == 3) ? 4 : 1;
        ab   = (cv[17:16] == 2'd0) ? 3 : 4;
        db   = int'(cv[13:12]);
        nb   = (cv[25:24] == 2'd0) ? 4 : (cv[25:24] == 2'd1) ? 8 : 16;
        x_cl = cl; x_l = l;
        x_cmdc = 8 / cl; x_addrc = ab * 8 / l; x_dumc = db * 8 / l;
        ecs  = int'(a >> WBITS);
        off  = 32'(a[WBITS-1:0]);
        if (wr_cfg) begin
            cfg_we = 1'b1;
            cfg_wdata = cv;
        end
        req_addr = a;
        req_valid = 1'b1;
        guard = 0;
        forever begin
            @(negedge clk);
            cfg_we = 1'b0;
            guard++;
            if (req_ready || guard > 5000) break;
        end
        check(req_ready, "R9", "ready pulse", 128'(req_ready), 128'd1);
        creq = (mode == 3) ? "R3" : "R1";
        check(cap_opc == cv[7:0], creq, "opcode", 128'(cap_opc), 128'(cv[7:0]));
        check(cap_addr == off, "R5", "address", 128'(cap_addr), 128'(off));
        check(cap_cs == ecs, "R8", "chip select", 128'(cap_cs), 128'(ecs));
        check(e_cnt == x_cmdc + x_addrc + x_dumc + nb * 8 / l, "R4", "sclk count",
              128'(e_cnt), 128'(x_cmdc + x_addrc + x_dumc + nb * 8 / l));
        check(oe_err == 0, "R2", "output enables", 128'(oe_err), 128'd0);
        exp_d = '0;
        for (int k = 0; k < nb; k++) exp_d[k*8 +: 8] = fbyte(ecs, off + 32'(k));
        check(rd_data == exp_d, "R6", "burst data", rd_data, exp_d);
        if (chained)
            check(last_gap == 2 * HALF + 1, "R10", "cs gap", 128'(last_gap), 128'(2 * HALF + 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] cv, lock_v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 32'h0300_100B, "R11", "reset config", 128'(cfg_rdata), 128'h0300100B);
        check(cs_any && !spi_sclk && !req_ready && spi_io_oe == 4'd0, "R10", "idle pins",
              128'({cs_any, spi_sclk, req_ready, spi_io_oe}), 128'({1'b1, 1'b0, 1'b0, 4'd0}));

        // Reset configuration used unchanged
        do_read(32'h0300_100B, {2'd2, 24'h00_1234}, 1'b0, 1'b0);

        // Chained sweep over every lane mode, dummy, address width and burst size
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 4; d++)
                for (int w = 0; w < 2; w++)
                    for (int b = 0; b < 4; b++) begin
                        int idx;
                        idx = ((m * 4 + d) * 2 + w) * 4 + b;
                        cv = {6'd0, 2'(b), 6'd0, 2'(w), 2'd0, 2'(d), 2'd0, 2'(m), 8'(idx * 29 + 3)};
                        do_read(cv, {2'(idx % 4), 24'(idx * 32'h0012_3457 + 32'hFFFF00)}, 1'b1, 1'b1);
                    end

        req_valid = 1'b0;
        repeat (6) @(negedge clk);

        // Lock: set, then try to overwrite
        lock_v = 32'h8301_21C5;
        cfg_we = 1'b1; cfg_wdata = lock_v;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == lock_v, "R7", "lock write", 128'(cfg_rdata), 128'(lock_v));
        cfg_we = 1'b1; cfg_wdata = 32'h0000_0011;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        check(cfg_rdata == lock_v, "R7", "write ignored", 128'(cfg_rdata), 128'(lock_v));
        do_read(lock_v, {2'd3, 24'hFFFF_F8}, 1'b0, 1'b0);

        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule